// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block is the interrupt logic of one UART channel. It holds an 8-bit interrupt enable register that is written over a simple register strobe. It gathers event flags from the rest of the channel: receive data, receive FIFO level, transmit readiness, line errors, modem changes, Xoff/special character detection, and the two flow-control pins. From these it drives one interrupt request line and a 6-bit status code. The code names the single most urgent enabled source.

Each source keeps its own pending state until its own service action clears it. Lower-priority sources stay pending while a higher one is reported.

A built-in idle timer measures how long received data has been waiting. It counts bit-clock enable pulses up to four character times plus twelve bit times, and raises a time-out source when it gets there.

The four upper enable bits control sleep, Xoff, RTS and CTS. They act only while the enhanced-features input is high.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset all enable bits are 0, `irq` is 0, `isr_code` is 6'h01 and `sleep_en` is 0.
- R2: Enable bit 0 gates receive data ready, reported as code 6'h04. With `fifo_en`=0 the condition is `rx_char_held`; with `fifo_en`=1 it is `rx_at_trig`. The source drops one clock after its condition goes low.
- R3: Enable bit 1 gates transmit ready, reported as code 6'h02. The condition is `thr_empty` (`fifo_en`=0) or `tx_below_trig` (`fifo_en`=1). The source becomes pending on a rising edge of that condition. It also becomes pending when bit 1 is written from 0 to 1 while the condition holds. It clears on `thr_wr`, or on an `isr_rd` while the code reads 6'h02.
- R4: Enable bit 2 gates line status, code 6'h06. Any set bit of the `lsr_err` event pulses makes it pending. It clears on `lsr_rd`.
- R5: Enable bit 3 gates modem status, code 6'h00. Any set bit of the `msr_chg` pulses makes it pending. It clears on `msr_rd` only; an `isr_rd` leaves it pending.
- R6: Enable bits 4..7 act only while `enh_en`=1. The bits are: bit 4 sleep (drives `sleep_en`), bit 5 Xoff/special, bit 6 RTS edge, bit 7 CTS edge.
- R7: Xoff/special detection is code 6'h10. A 0-to-1 edge on `cts_n_pin` while `auto_cts_en`=1, or on `rts_n_pin` while `auto_rts_en`=1, is code 6'h20. Both sources clear on an `isr_rd` that returns their code.
- R8: With `fifo_en`=1 and enable bit 0 set, time-out (code 6'h0C) is raised on the (4*`char_bits`+12)-th `bit_tick` while `rx_nonempty` holds. The count restarts on `rx_char_stb`, on `rx_fifo_rd`, or when the FIFO is empty, and each restart also clears the source.
- R9: Priority from highest to lowest is: line status, time-out, data ready, transmit ready, modem status, Xoff/special, pin edge. `isr_code` shows the highest enabled pending source. It reads 6'h01 when none is pending.
- R10: `irq` is high exactly when an enabled source is pending. It follows an event or an enable write by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced features allow upper enable bits |
| fifo_en | input | 1 | FIFO mode select |
| auto_cts_en | input | 1 | Automatic CTS flow control active |
| auto_rts_en | input | 1 | Automatic RTS flow control active |
| char_bits | input | 4 | Bit times per character frame |
| bit_tick | input | 1 | One pulse per bit time |
| rx_char_held | input | 1 | Holding register has a character (non-FIFO) |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_char_stb | input | 1 | A character was just received |
| rx_fifo_rd | input | 1 | Host read from the receive FIFO |
| thr_empty | input | 1 | Transmit holding register empty (non-FIFO) |
| tx_below_trig | input | 1 | Transmit FIFO below trigger level |
| thr_wr | input | 1 | Host write to the transmit holding register |
| lsr_err | input | 4 | Line error event pulses |
| lsr_rd | input | 1 | Line status read strobe |
| msr_chg | input | 4 | Modem change event pulses |
| msr_rd | input | 1 | Modem status read strobe |
| xoff_det | input | 1 | Xoff or special character detected pulse |
| cts_n_pin | input | 1 | CTS# pin level |
| rts_n_pin | input | 1 | RTS# pin level |
| isr_rd | input | 1 | Status register read strobe |
| irq | output | 1 | Interrupt request |
| isr_code | output | 6 | Highest pending source code |
| sleep_en | output | 1 | Effective sleep enable |

## Verification
Several sources are made pending at once and then serviced one by one. This shows that the code follows the stated priority and that each service action clears only its own source. Data ready is tried in both FIFO and non-FIFO modes, to show the mode picks the right condition. Transmit ready is raised two ways, by a condition edge and by enabling while the condition already holds, which separates the two set paths. The time-out is probed one tick before and at the exact limit to pin the count. The upper sources are driven with the enhanced input low and then high, which shows the gating.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 7;
  localparam int S_LS = 0, S_TO = 1, S_DR = 2, S_TX = 3, S_MS = 4, S_XF = 5, S_PE = 6;
  localparam logic [5:0] C_NONE = 6'h01, C_LS = 6'h06, C_TO = 6'h0C, C_DR = 6'h04,
                         C_TX = 6'h02, C_MS = 6'h00, C_XF = 6'h10, C_PE = 6'h20;

  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      S_LS: src_code = C_LS;
      S_TO: src_code = C_TO;
      S_DR: src_code = C_DR;
      S_TX: src_code = C_TX;
      S_MS: src_code = C_MS;
      S_XF: src_code = C_XF;
      default: src_code = C_PE;
    endcase
  endfunction

  // idle limit in bit times: four characters plus twelve bits
  function automatic int idle_limit(input logic [3:0] cbits);
    idle_limit = 4 * int'(cbits) + 12;
  endfunction
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic [3:0] char_bits,
  input  logic       bit_tick,
  input  logic       rx_nonempty,
  input  logic       rx_char_stb,
  input  logic       rx_fifo_rd,
  output logic       to_pend
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             restart;
  logic             hit;

  assign last    = CNT_W'(idle_limit(char_bits) - 1);
  assign restart = rx_char_stb | rx_fifo_rd | ~rx_nonempty | ~fifo_en;
  assign hit     = bit_tick & ~to_pend & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      to_pend <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      to_pend <= 1'b0;
    end else if (bit_tick && !to_pend) begin
      if (hit) to_pend <= 1'b1;
      else     cnt     <= cnt + 1'b1;
    end
  end

  AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    to_pend |-> $past(rx_nonempty) && $past(fifo_en)); // R8
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_stb || rx_fifo_rd) |=> !to_pend && cnt == '0); // R8
endmodule

// File: rtl/uart_irq_events.sv
module uart_irq_events
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ier_we,
  input  logic [7:0]      ier_wdata,
  input  logic            enh_en,
  input  logic            fifo_en,
  input  logic            auto_cts_en,
  input  logic            auto_rts_en,
  input  logic            rx_char_held,
  input  logic            rx_at_trig,
  input  logic            thr_empty,
  input  logic            tx_below_trig,
  input  logic            thr_wr,
  input  logic [3:0]      lsr_err,
  input  logic            lsr_rd,
  input  logic [3:0]      msr_chg,
  input  logic            msr_rd,
  input  logic            xoff_det,
  input  logic            cts_n_pin,
  input  logic            rts_n_pin,
  input  logic            isr_rd,
  input  logic [5:0]      cur_code,
  input  logic            to_pend,
  output logic [NSRC-1:0] act,
  output logic            sleep_en
);
  logic [7:0] ier, ier_eff;
  logic ls_p, dr_p, tx_p, ms_p, xf_p, cts_p, rts_p;
  logic tx_cond, tx_cond_q, cts_q, rts_q;
  logic tx_set, tx_clr, cts_rise, rts_rise, rd_xf, rd_pe;

  assign ier_eff  = {ier[7:4] & {4{enh_en}}, ier[3:0]};
  assign sleep_en = ier_eff[4];
  assign tx_cond  = fifo_en ? tx_below_trig : thr_empty;
  // pending on a rising condition, or when enabled while the condition holds
  assign tx_set   = tx_cond & (~tx_cond_q | (ier_we & ier_wdata[1] & ~ier[1]));
  assign tx_clr   = thr_wr | (isr_rd & (cur_code == C_TX));
  assign cts_rise = auto_cts_en & cts_n_pin & ~cts_q;
  assign rts_rise = auto_rts_en & rts_n_pin & ~rts_q;
  assign rd_xf    = isr_rd & (cur_code == C_XF);
  assign rd_pe    = isr_rd & (cur_code == C_PE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0;
      {ls_p, dr_p, tx_p, ms_p, xf_p, cts_p, rts_p} <= '0;
      {tx_cond_q, cts_q, rts_q} <= '0;
    end else begin
      if (ier_we) ier <= ier_wdata;
      tx_cond_q <= tx_cond;
      cts_q     <= cts_n_pin;
      rts_q     <= rts_n_pin;
      ls_p  <= (ls_p & ~lsr_rd) | (|lsr_err);
      ms_p  <= (ms_p & ~msr_rd) | (|msr_chg);
      dr_p  <= fifo_en ? rx_at_trig : rx_char_held;
      tx_p  <= ~thr_wr & ((tx_p & ~tx_clr) | tx_set);
      xf_p  <= (xf_p & ~rd_xf) | xoff_det;
      cts_p <= (cts_p & ~rd_pe) | cts_rise;
      rts_p <= (rts_p & ~rd_pe) | rts_rise;
    end
  end

  always_comb begin
    act       = '0;
    act[S_LS] = ls_p & ier_eff[2];
    act[S_TO] = to_pend & ier_eff[0];
    act[S_DR] = dr_p & ier_eff[0];
    act[S_TX] = tx_p & ier_eff[1];
    act[S_MS] = ms_p & ier_eff[3];
    act[S_XF] = xf_p & ier_eff[5];
    act[S_PE] = (cts_p & ier_eff[7]) | (rts_p & ier_eff[6]);
  end

  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !tx_p); // R3
  AST_LS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && lsr_err == 4'd0) |=> !ls_p); // R4
  AST_MS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_p && !msr_rd) |=> ms_p); // R5
  AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> !act[S_XF] && !act[S_PE] && !sleep_en); // R6
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output logic [5:0]      code
);
  always_comb begin
    code = C_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  input  logic       enh_en,
  input  logic       fifo_en,
  input  logic       auto_cts_en,
  input  logic       auto_rts_en,
  input  logic [3:0] char_bits,
  input  logic       bit_tick,
  input  logic       rx_char_held,
  input  logic       rx_at_trig,
  input  logic       rx_nonempty,
  input  logic       rx_char_stb,
  input  logic       rx_fifo_rd,
  input  logic       thr_empty,
  input  logic       tx_below_trig,
  input  logic       thr_wr,
  input  logic [3:0] lsr_err,
  input  logic       lsr_rd,
  input  logic [3:0] msr_chg,
  input  logic       msr_rd,
  input  logic       xoff_det,
  input  logic       cts_n_pin,
  input  logic       rts_n_pin,
  input  logic       isr_rd,
  output logic       irq,
  output logic [5:0] isr_code,
  output logic       sleep_en
);
  logic            to_pend;
  logic [NSRC-1:0] act;

  uart_irq_timeout #(.CNT_W(CNT_W)) u_timeout (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .char_bits(char_bits),
    .bit_tick(bit_tick), .rx_nonempty(rx_nonempty), .rx_char_stb(rx_char_stb),
    .rx_fifo_rd(rx_fifo_rd), .to_pend(to_pend)
  );

  uart_irq_events u_events (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .enh_en(enh_en), .fifo_en(fifo_en), .auto_cts_en(auto_cts_en),
    .auto_rts_en(auto_rts_en), .rx_char_held(rx_char_held), .rx_at_trig(rx_at_trig),
    .thr_empty(thr_empty), .tx_below_trig(tx_below_trig), .thr_wr(thr_wr),
    .lsr_err(lsr_err), .lsr_rd(lsr_rd), .msr_chg(msr_chg), .msr_rd(msr_rd),
    .xoff_det(xoff_det), .cts_n_pin(cts_n_pin), .rts_n_pin(rts_n_pin),
    .isr_rd(isr_rd), .cur_code(isr_code), .to_pend(to_pend), .act(act),
    .sleep_en(sleep_en)
  );

  uart_irq_prio u_prio (.act(act), .code(isr_code));

  assign irq = |act;

  AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !isr_code[0]); // R10
  AST_LS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    act[S_LS] |-> isr_code == C_LS); // R9
  AST_CODE_IDLE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    isr_code[0] |-> isr_code[5:1] == 5'd0); // R9
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic ier_we = 0; logic [7:0] ier_wdata = 0;
  logic enh_en = 0, fifo_en = 0, auto_cts_en = 0, auto_rts_en = 0;
  logic [3:0] char_bits = 4'd10;
  logic bit_tick = 0, rx_char_held = 0, rx_at_trig = 0, rx_nonempty = 0;
  logic rx_char_stb = 0, rx_fifo_rd = 0, thr_empty = 0, tx_below_trig = 0, thr_wr = 0;
  logic [3:0] lsr_err = 0, msr_chg = 0;
  logic lsr_rd = 0, msr_rd = 0, xoff_det = 0, cts_n_pin = 0, rts_n_pin = 0, isr_rd = 0;
  logic irq, sleep_en; logic [5:0] isr_code;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // code and irq together; irq must be high exactly when a code is shown
  task automatic expect_code(input string req, input logic [5:0] c);
    check(req, {2'b0, isr_code}, {2'b0, c});
    check(req, {7'b0, irq}, {7'b0, c != 6'h01});
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1; ier_wdata = v; @(negedge clk); ier_we = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset;
    expect_code("R1", 6'h01);
    check("R1 sleep", {7'b0, sleep_en}, 8'h00);
  endtask

  task automatic t_data_ready;
    wr_ier(8'h01);
    rx_char_held = 1; @(negedge clk);
    expect_code("R2 nonfifo", 6'h04);
    rx_char_held = 0; @(negedge clk);
    expect_code("R2 drop", 6'h01);
    fifo_en = 1; rx_char_held = 1; @(negedge clk);
    expect_code("R2 fifo ignores held", 6'h01);
    rx_at_trig = 1; @(negedge clk);
    expect_code("R2 fifo trig", 6'h04);
    rx_at_trig = 0; rx_char_held = 0; fifo_en = 0; @(negedge clk);
    expect_code("R2 fifo clear", 6'h01);
  endtask

  task automatic t_tx;
    thr_empty = 1; @(negedge clk);
    expect_code("R10 masked tx", 6'h01);
    wr_ier(8'h02);
    expect_code("R3 enable while empty", 6'h02);
    pulse(isr_rd);
    expect_code("R3 read clears", 6'h01);
    thr_empty = 0; @(negedge clk); thr_empty = 1; @(negedge clk);
    expect_code("R3 empty edge", 6'h02);
    pulse(thr_wr);
    expect_code("R3 write clears", 6'h01);
    thr_empty = 0; wr_ier(8'h00);
  endtask

  task automatic t_priority;
    wr_ier(8'h0F);
    rx_char_held = 1; lsr_err = 4'b0100; msr_chg = 4'b0001; thr_empty = 1;
    @(negedge clk); lsr_err = 0; msr_chg = 0;
    expect_code("R9 ls first", 6'h06);
    pulse(lsr_rd);
    expect_code("R4 cleared, R9 dr next", 6'h04);
    rx_char_held = 0; @(negedge clk);
    expect_code("R9 tx next", 6'h02);
    pulse(isr_rd);
    expect_code("R9 ms next", 6'h00);
    pulse(isr_rd);
    expect_code("R5 isr read ignored", 6'h00);
    pulse(msr_rd);
    expect_code("R5 cleared", 6'h01);
    thr_empty = 0; wr_ier(8'h00);
    lsr_err = 4'b0010; @(negedge clk); lsr_err = 0;
    expect_code("R4 masked", 6'h01);
    pulse(lsr_rd);
  endtask

  task automatic t_upper;
    wr_ier(8'hF0);
    check("R6 sleep gated", {7'b0, sleep_en}, 8'h00);
    pulse(xoff_det);
    auto_cts_en = 1; cts_n_pin = 1; @(negedge clk);
    expect_code("R6 gated upper", 6'h01);
    enh_en = 1; @(negedge clk);
    check("R6 sleep on", {7'b0, sleep_en}, 8'h01);
    expect_code("R7 xoff", 6'h10);
    pulse(isr_rd);
    expect_code("R7 edge after xoff", 6'h20);
    pulse(isr_rd);
    expect_code("R7 edge cleared", 6'h01);
    rts_n_pin = 1; @(negedge clk);
    expect_code("R7 rts needs auto", 6'h01);
    rts_n_pin = 0; auto_rts_en = 1; @(negedge clk);
    rts_n_pin = 1; @(negedge clk);
    expect_code("R7 rts edge", 6'h20);
    pulse(isr_rd);
    wr_ier(8'h00); enh_en = 0; auto_cts_en = 0; auto_rts_en = 0;
    expect_code("R7 done", 6'h01);
  endtask

  task automatic t_timeout;
    wr_ier(8'h01);
    fifo_en = 1; rx_nonempty = 1; char_bits = 4'd10;
    pulse(rx_char_stb);
    bit_tick = 1; repeat (51) @(negedge clk); bit_tick = 0;
    expect_code("R8 before limit", 6'h01);
    pulse(bit_tick);
    expect_code("R8 at limit 52", 6'h0C);
    pulse(rx_fifo_rd);
    expect_code("R8 read restarts", 6'h01);
    char_bits = 4'd7;
    bit_tick = 1; repeat (40) @(negedge clk); bit_tick = 0;
    expect_code("R8 limit 40", 6'h0C);
    rx_nonempty = 0; @(negedge clk);
    expect_code("R8 empty clears", 6'h01);
    fifo_en = 0; wr_ier(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_data_ready();
    t_tx();
    t_priority();
    t_upper();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule